// File: doc/BRIEF.md
# Node error aggregator with watchdog reset

This block gathers eight hardware error flags from a processing node and turns them into one latched non-maskable interrupt line. Once the interrupt is raised, software cannot lower it. The processors are expected to stop servicing the watchdog. The block's own watchdog counter then runs out and drives a node-wide reset pulse, and that pulse is the only thing that lowers the interrupt.

A sticky cause vector records every source seen. A separate field records the index of the source that fired first. Both survive the watchdog pulse, so diagnostic code running after the restart can read what went wrong. They are cleared only by the synchronous power-on reset, or by a clear strobe issued once the cause has been read.

Top module: `node_err_agg`

## Requirements
- R1: While `rst` is high, on the following edge `nmi` and `node_rst` go low, `cause` goes to zero and `first_valid` goes low. This happens even if an interrupt or cause was pending.
- R2: If any `err_in` bit is high on a clock edge while `node_rst` is low, `nmi` is high from that edge on.
- R3: `nmi` stays high until the watchdog pulse. It goes low on the edge after `node_rst` first reads high. Errors seen while `node_rst` is high do not raise `nmi`, but they are still recorded in `cause`.
- R4: Bit i of `cause` is set on the edge where `err_in[i]` is high, and it stays set. The bit order is: 0 communication CPU halted, 1 power failure, 2 parity error, 3 FIFO over/underflow, 4 access to absent memory, 5 network write outside the node's time slot, 6 external device error, 7 peer unit error.
- R5: On the first error edge after a clear, `first_valid` goes high and `first_idx` takes the lowest set index among that edge's `err_in` bits. Later errors leave `first_idx` unchanged.
- R6: A `kick` seen while `nmi` is low loads the counter with `reload_val`. With no further effective kick, `node_rst` rises on the (`reload_val`+1)th edge after the loading edge.
- R7: `kick` has no effect while `nmi` is high or while `node_rst` is high. An error therefore always leads to a reset pulse `reload_val`+1 edges after the last effective kick.
- R8: `node_rst` stays high for exactly `RST_CYCLES` (16) cycles. The counter is then reloaded from `reload_val`.
- R9: The watchdog pulse leaves `cause`, `first_valid` and `first_idx` unchanged.
- R10: `cause_clr` empties `cause` and `first_valid`. Errors present on the same edge are recorded into the emptied state, including as the first error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| err_in | input | N_SRC | Error flags, one per source (order in R4) |
| kick | input | 1 | Watchdog service strobe |
| reload_val | input | CNT_W | Watchdog reload value |
| cause_clr | input | 1 | Clears cause vector and first-error field |
| nmi | output | 1 | Latched non-maskable interrupt |
| node_rst | output | 1 | Node-wide reset pulse from the watchdog |
| cause | output | N_SRC | Sticky record of sources seen |
| first_valid | output | 1 | First-error field holds a value |
| first_idx | output | IDX_W | Index of the first source to fire |

## Verification
The interrupt path is driven in four ways: a single source alone, three sources on one edge followed by a fourth, a source arriving in the middle of the reset pulse, and a source coinciding with the clear strobe. The single source shows the bit mapping. The simultaneous burst separates lowest-index priority from arrival order. The mid-pulse error separates cause recording from interrupt raising. The clear collision shows which of clear and capture wins. A pure timeout with kicks withheld is compared against an error with kicks held high, which shows that kicks are masked by the interrupt. The exact rise and fall edges of the pulse measure the timeout and the pulse width.

// File: rtl/node_err_pkg.sv
package node_err_pkg;
  localparam int NODE_SRC_N    = 8;
  localparam int NODE_CNT_W    = 16;
  localparam int NODE_RST_LEN  = 16;

  typedef enum logic [2:0] {
    SRC_COMM_HALT  = 3'd0,
    SRC_POWER      = 3'd1,
    SRC_PARITY     = 3'd2,
    SRC_FIFO       = 3'd3,
    SRC_NO_MEM     = 3'd4,
    SRC_SLOT_WRITE = 3'd5,
    SRC_EXT_DEV    = 3'd6,
    SRC_PEER       = 3'd7
  } err_src_e;
endpackage

// File: rtl/err_capture.sv
module err_capture #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     err_i,
  input  logic             clr_i,
  output logic [N-1:0]     cause_o,
  output logic             first_valid_o,
  output logic [IDX_W-1:0] first_idx_o
);
  logic [IDX_W-1:0] low_idx;
  logic             any_err;

  assign any_err = |err_i;

  // lowest set index wins
  always_comb begin
    low_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (err_i[i]) low_idx = IDX_W'(i);
    end
  end

  // one sticky flop per source
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)        cause_o[g] <= 1'b0;
      else if (clr_i) cause_o[g] <= err_i[g];
      else if (err_i[g]) cause_o[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_valid_o <= 1'b0;
      first_idx_o   <= '0;
    end else if (clr_i) begin
      first_valid_o <= any_err;
      first_idx_o   <= low_idx;
    end else if (!first_valid_o && any_err) begin
      first_valid_o <= 1'b1;
      first_idx_o   <= low_idx;
    end
  end

  p_cause_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

  p_first_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (first_valid_o && !clr_i) |=> (first_valid_o && $stable(first_idx_o)));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 16,
  parameter int HOLD_W     = $clog2(RST_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kick_i,
  input  logic             nmi_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             node_rst_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [HOLD_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= reload_i;
      hold_q     <= '0;
      node_rst_o <= 1'b0;
    end else if (node_rst_o) begin
      hold_q <= hold_q - HOLD_W'(1);
      if (hold_q == HOLD_W'(1)) begin
        node_rst_o <= 1'b0;
        cnt_q      <= reload_i;
      end
    end else if (kick_i && !nmi_i) begin
      cnt_q <= reload_i;
    end else if (cnt_q == '0) begin
      node_rst_o <= 1'b1;
      hold_q     <= HOLD_W'(RST_CYCLES);
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  p_kick_masked_r7: assert property (@(posedge clk) disable iff (rst)
    (nmi_i && !node_rst_o && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_pulse_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (node_rst_o && hold_q > HOLD_W'(1)) |=> node_rst_o);
endmodule

// File: rtl/node_err_agg.sv
module node_err_agg #(
  parameter int N_SRC      = node_err_pkg::NODE_SRC_N,
  parameter int CNT_W      = node_err_pkg::NODE_CNT_W,
  parameter int RST_CYCLES = node_err_pkg::NODE_RST_LEN,
  parameter int IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] err_in,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             cause_clr,
  output logic             nmi,
  output logic             node_rst,
  output logic [N_SRC-1:0] cause,
  output logic             first_valid,
  output logic [IDX_W-1:0] first_idx
);
  // interrupt latch: only the watchdog pulse or power-on reset lowers it
  always_ff @(posedge clk) begin
    if (rst)           nmi <= 1'b0;
    else if (node_rst) nmi <= 1'b0;
    else if (|err_in)  nmi <= 1'b1;
  end

  err_capture #(.N(N_SRC), .IDX_W(IDX_W)) u_cap (
    .clk          (clk),
    .rst          (rst),
    .err_i        (err_in),
    .clr_i        (cause_clr),
    .cause_o      (cause),
    .first_valid_o(first_valid),
    .first_idx_o  (first_idx)
  );

  wdog_timer #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_wdog (
    .clk       (clk),
    .rst       (rst),
    .kick_i    (kick),
    .nmi_i     (nmi),
    .reload_i  (reload_val),
    .node_rst_o(node_rst)
  );

  p_err_nmi_r2: assert property (@(posedge clk) disable iff (rst)
    ((|err_in) && !node_rst) |=> nmi);

  p_nmi_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (nmi && !node_rst) |=> nmi);

  p_pulse_drops_nmi_r3: assert property (@(posedge clk) disable iff (rst)
    (node_rst && $past(node_rst)) |-> !nmi);
endmodule

// File: tb/node_err_agg_tb.sv
module node_err_agg_tb;
  localparam int N  = 8;
  localparam int R  = 20;
  localparam int K_NMI = 0, K_RST = 1, K_CAUSE = 2, K_FV = 3, K_FI = 4;

  typedef struct {
    int    at;
    int    kind;
    int    exp;
    string tag;
  } exp_t;

  logic         clk = 0;
  logic         rst = 1;
  logic [N-1:0] err_in = '0;
  logic         kick = 0;
  logic [15:0]  reload_val = 16'(R);
  logic         cause_clr = 0;
  logic         nmi, node_rst, first_valid;
  logic [N-1:0] cause;
  logic [2:0]   first_idx;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  node_err_agg u_dut (
    .clk(clk), .rst(rst), .err_in(err_in), .kick(kick),
    .reload_val(reload_val), .cause_clr(cause_clr),
    .nmi(nmi), .node_rst(node_rst), .cause(cause),
    .first_valid(first_valid), .first_idx(first_idx)
  );

  function automatic int probe(int kind);
    case (kind)
      K_NMI:   return int'(nmi);
      K_RST:   return int'(node_rst);
      K_CAUSE: return int'(cause);
      K_FV:    return int'(first_valid);
      default: return int'(first_idx);
    endcase
  endfunction

  task automatic expect_in(int dly, int kind, int val, string tag);
    exp_t e;
    e.at = cyc + dly; e.kind = kind; e.exp = val; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic at_cycle(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: compare every item due this cycle
  always @(negedge clk) begin
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].at == cyc) begin
        checks++;
        if (probe(exp_q[i].kind) != exp_q[i].exp) begin
          fails++;
          $display("FAIL %s kind=%0d cyc=%0d actual=%0d expected=%0d",
                   exp_q[i].tag, exp_q[i].kind, cyc,
                   probe(exp_q[i].kind), exp_q[i].exp);
        end
        exp_q.delete(i);
      end
    end
  end

  initial begin
    int t;
    @(negedge clk); @(negedge clk);
    // reset state
    expect_in(1, K_NMI, 0, "R1"); expect_in(1, K_RST, 0, "R1");
    expect_in(1, K_CAUSE, 0, "R1"); expect_in(1, K_FV, 0, "R1");
    @(negedge clk); @(negedge clk);
    rst = 0; kick = 1;
    repeat (30) @(negedge clk);
    expect_in(1, K_RST, 0, "R6");

    // pure timeout: last kick at t
    t = cyc;
    expect_in(R + 1, K_RST, 0, "R6");
    expect_in(R + 2, K_RST, 1, "R6");
    expect_in(R + 2, K_NMI, 0, "R6");
    expect_in(R + 17, K_RST, 1, "R8");
    expect_in(R + 18, K_RST, 0, "R8");
    at_cycle(t + 1); kick = 0;
    at_cycle(t + R + 19); kick = 1;
    at_cycle(t + R + 40);
    expect_in(1, K_RST, 0, "R6");

    // single source: slot violation (bit 5), kicks kept high
    at_cycle(cyc + 2);
    t = cyc;
    err_in = 8'h20;
    expect_in(1, K_NMI, 1, "R2");
    expect_in(1, K_CAUSE, 8'h20, "R4");
    expect_in(1, K_FV, 1, "R5");
    expect_in(1, K_FI, 5, "R5");
    expect_in(10, K_NMI, 1, "R3");
    expect_in(R + 1, K_RST, 0, "R7");
    expect_in(R + 2, K_RST, 1, "R7");
    expect_in(R + 2, K_NMI, 1, "R3");
    expect_in(R + 3, K_NMI, 0, "R3");
    expect_in(R + 7, K_CAUSE, 8'h22, "R3");
    expect_in(R + 8, K_NMI, 0, "R3");
    expect_in(R + 17, K_RST, 1, "R8");
    expect_in(R + 18, K_RST, 0, "R8");
    expect_in(R + 18, K_CAUSE, 8'h22, "R9");
    expect_in(R + 18, K_FV, 1, "R9");
    expect_in(R + 18, K_FI, 5, "R9");
    expect_in(R + 20, K_NMI, 0, "R3");
    at_cycle(t + 1); err_in = '0;
    at_cycle(t + R + 6); err_in = 8'h02;
    at_cycle(t + R + 7); err_in = '0;
    at_cycle(t + R + 60);
    expect_in(1, K_RST, 0, "R6");

    // clear
    at_cycle(cyc + 2);
    cause_clr = 1;
    expect_in(1, K_CAUSE, 0, "R10"); expect_in(1, K_FV, 0, "R10");
    @(negedge clk); cause_clr = 0;

    // simultaneous sources 2,4,7 then source 0
    at_cycle(cyc + 2);
    t = cyc;
    err_in = 8'h94;
    expect_in(1, K_CAUSE, 8'h94, "R4"); expect_in(1, K_FI, 2, "R5");
    expect_in(2, K_CAUSE, 8'h95, "R4"); expect_in(2, K_FI, 2, "R5");
    expect_in(R + 2, K_RST, 1, "R7");
    at_cycle(t + 1); err_in = 8'h01;
    at_cycle(t + 2); err_in = '0;
    at_cycle(t + R + 25);

    // clear colliding with error on bit 3
    t = cyc;
    cause_clr = 1; err_in = 8'h08;
    expect_in(1, K_CAUSE, 8'h08, "R10"); expect_in(1, K_FV, 1, "R10");
    expect_in(1, K_FI, 3, "R10");
    at_cycle(t + 1); cause_clr = 0; err_in = '0;
    at_cycle(t + R + 25);

    // power-on reset while interrupt and cause pending
    t = cyc;
    err_in = 8'h40;
    expect_in(3, K_NMI, 1, "R2");
    expect_in(3, K_CAUSE, 8'h48, "R4");
    expect_in(4, K_NMI, 0, "R1"); expect_in(4, K_CAUSE, 0, "R1");
    expect_in(4, K_FV, 0, "R1");
    at_cycle(t + 1); err_in = '0;
    at_cycle(t + 3); rst = 1;
    at_cycle(t + 5); rst = 0;
    at_cycle(t + 8);
    done = 1;
  end

  initial begin
    wait (done || cyc > 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
    end
    foreach (exp_q[i]) begin
      checks++; fails++;
      $display("FAIL %s unchecked item actual=%0d expected=%0d",
               exp_q[i].tag, cyc, exp_q[i].at);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule